// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns the three rotor-position sensor signals of a brushless motor into drive commands for a three-leg power bridge. Each leg is told to connect its output to the supply rail (high-side switch on), to ground (low-side switch on), or to float (both switches off). The decoder accepts sensors mounted either 60 or 120 electrical degrees apart. It has no configuration pin for this, because it decodes all eight possible sensor codes at once. Two codes that mean the same rotor position under the two spacings produce the same drive. Sensor layouts of 240 and 300 degrees are the 120 and 60 degree sequences run backwards, so they are covered as well.

A direction input swaps the supply and ground assignment of the two driven legs, which reverses the torque. An active-low brake input closes all three high-side switches. An enable input opens every switch and takes priority over both brake and commutation. Every input passes through a two-flop synchroniser. The drive pattern is then registered, so the switch enables are glitch-free flop outputs.

Top module: `hall_commutator`

## Requirements
- R1: While reset is asserted and after it is released, before any input has propagated, all six switch enables are 0.
- R2: With enable high, brake high and direction high (forward), the sensor codes {H1,H2,H3}, where H1 is hall_i[0], H2 is hall_i[1] and H3 is hall_i[2], drive the legs as follows, written as (leg1,leg2,leg3) with V for high, G for low and Z for float. 100 gives (V,Z,G). 110 gives (Z,V,G). 011 gives (G,Z,V). 001 gives (Z,G,V).
- R3: Under the same conditions, the codes that occur only with 120-degree spacing drive as follows. 010 gives (G,V,Z). 101 gives (V,G,Z).
- R4: Under the same conditions, the codes that occur only with 60-degree spacing decode to the same pattern as their 120-degree twin. 111 gives (G,V,Z). 000 gives (V,G,Z).
- R5: With direction low (reverse), each driven leg swaps V and G relative to R2 to R4, and the floating leg stays floating.
- R6: When enable and brake are both high, exactly one leg is high and exactly one leg is low. No leg ever has both of its switches on.
- R7: With enable low, all six switch enables are 0, whatever the brake, direction and sensor inputs are.
- R8: With enable high and brake low, all three high-side enables are 1 and all low-side enables are 0, whatever the direction and sensor inputs are.
- R9: A change at any input shows at the outputs after exactly three rising clock edges: two synchroniser stages and one output register. The outputs hold their previous value after the second of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Sensor inputs; bit 0 is H1, bit 1 is H2, bit 2 is H3 |
| fwd_i | input | 1 | Direction: 1 forward, 0 reverse |
| en_i | input | 1 | Bridge enable, active high |
| brake_ni | input | 1 | Brake request, active low |
| hs_en_o | output | 3 | High-side switch enable per leg, bit 0 is leg 1 |
| ls_en_o | output | 3 | Low-side switch enable per leg, bit 0 is leg 1 |

## Verification
The bench changes inputs only at falling edges. Each result is due after the third rising edge that follows the change: two edges cross the synchroniser and one loads the output register. For each stimulus, the bench samples at the falling edge after the second rising edge and expects the old pattern. It samples again at the falling edge after the third rising edge and expects the new pattern. The sweep covers all eight sensor codes in both directions, together with every combination of enable and brake. Expected patterns come from a rotor-position index and leg arithmetic, not from a copied table.

// File: rtl/hall_commutator_pkg.sv
package hall_commutator_pkg;
  localparam int unsigned NUM_LEGS  = 3;
  localparam int unsigned NUM_POS   = 6;
  localparam int unsigned POS_W     = $clog2(NUM_POS);

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [1:0] {
    LEG_FLOAT = 2'b00,
    LEG_LOW   = 2'b01,
    LEG_HIGH  = 2'b10
  } leg_state_e;

  function automatic logic [NUM_POS-1:0] rot_pos(logic [NUM_POS-1:0] v, int unsigned n);
    logic [NUM_POS-1:0] r;
    r = v;
    for (int unsigned i = 0; i < n; i++) r = {r[NUM_POS-2:0], r[NUM_POS-1]};
    return r;
  endfunction
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= rst_val_i;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hall_pos_decode.sv
module hall_pos_decode
  import hall_commutator_pkg::*;
(
  input  logic [2:0] hall_i,
  output pos_t       pos_o
);
  // Twin codes of the two spacings collapse onto one position index.
  always_comb begin
    unique case (hall_i)
      3'b001:          pos_o = pos_t'(0);
      3'b011:          pos_o = pos_t'(1);
      3'b010, 3'b111:  pos_o = pos_t'(2);
      3'b110:          pos_o = pos_t'(3);
      3'b100:          pos_o = pos_t'(4);
      default:         pos_o = pos_t'(5); // 101 and 000
    endcase
  end
endmodule

// File: rtl/leg_drive.sv
module leg_drive
  import hall_commutator_pkg::*;
#(
  parameter int unsigned LEG_IDX = 0
) (
  input  pos_t       pos_i,
  input  logic       fwd_i,
  output leg_state_e state_o
);
  localparam logic [NUM_POS-1:0] HIGH_BASE = 6'b100001;
  localparam logic [NUM_POS-1:0] LOW_BASE  = 6'b001100;
  localparam logic [NUM_POS-1:0] HIGH_MASK = rot_pos(HIGH_BASE, 2*LEG_IDX);
  localparam logic [NUM_POS-1:0] LOW_MASK  = rot_pos(LOW_BASE, 2*LEG_IDX);

  logic src_hi, src_lo;
  assign src_hi = HIGH_MASK[pos_i];
  assign src_lo = LOW_MASK[pos_i];

  always_comb begin
    state_o = LEG_FLOAT;
    if (src_hi)      state_o = fwd_i ? LEG_HIGH : LEG_LOW;
    else if (src_lo) state_o = fwd_i ? LEG_LOW  : LEG_HIGH;
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_commutator_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       fwd_i,
  input  logic       en_i,
  input  logic       brake_ni,
  output logic [2:0] hs_en_o,
  output logic [2:0] ls_en_o
);
  localparam int unsigned SYNC_W = 6;

  logic [SYNC_W-1:0] sync_q;
  logic [2:0]        hall_s;
  logic              fwd_s, en_s, brake_ns;

  hall_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({brake_ni, en_i, fwd_i, hall_i}),
    .rst_val_i(6'b100000),
    .q_o      (sync_q)
  );
  assign {brake_ns, en_s, fwd_s, hall_s} = sync_q;

  pos_t pos;
  hall_pos_decode i_decode (.hall_i(hall_s), .pos_o(pos));

  leg_state_e        leg_state [NUM_LEGS];
  logic [NUM_LEGS-1:0] hs_d, ls_d;

  generate
    for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
      leg_drive #(.LEG_IDX(l)) i_leg (
        .pos_i  (pos),
        .fwd_i  (fwd_s),
        .state_o(leg_state[l])
      );
      always_comb begin
        if (!en_s) begin
          hs_d[l] = 1'b0;
          ls_d[l] = 1'b0;
        end else if (!brake_ns) begin
          hs_d[l] = 1'b1;
          ls_d[l] = 1'b0;
        end else begin
          hs_d[l] = (leg_state[l] == LEG_HIGH);
          ls_d[l] = (leg_state[l] == LEG_LOW);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_en_o <= '0;
      ls_en_o <= '0;
    end else begin
      hs_en_o <= hs_d;
      ls_en_o <= ls_d;
    end
  end

  assert_no_shoot_through_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o & ls_en_o) == 3'b000);

  assert_run_two_legs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && brake_ns) |=> ($countones(hs_en_o) == 1 && $countones(ls_en_o) == 1));

  assert_disable_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

  assert_brake_high_side_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && !brake_ns) |=> (hs_en_o == 3'b111 && ls_en_o == 3'b000));

  assert_reverse_swaps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && brake_ns && !fwd_s && $stable(hall_s) && $stable(en_s) && $stable(brake_ns)
     && $past(fwd_s)) |=> (hs_en_o == $past(ls_en_o) && ls_en_o == $past(hs_en_o)));
endmodule

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       fwd = 1'b1, en = 1'b0, brake_n = 1'b1;
  logic [2:0] hs, ls;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  hall_commutator i_hall_commutator (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .fwd_i(fwd),
    .en_i(en), .brake_ni(brake_n), .hs_en_o(hs), .ls_en_o(ls)
  );

  // Rotor position index 0..5 from code {H3,H2,H1}; twins share an index.
  function automatic int pos_of(logic [2:0] c);
    case (c)
      3'b001: return 0;
      3'b011: return 1;
      3'b010, 3'b111: return 2;
      3'b110: return 3;
      3'b100: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [5:0] expect_of(logic [2:0] c, logic f, logic e, logic b);
    int p, hi, lo, t;
    logic [2:0] eh, el;
    if (!e) return 6'b000000;
    if (!b) return {3'b111, 3'b000};
    p  = pos_of(c);
    hi = ((p + 1) / 2) % 3;
    lo = ((p + 4) / 2) % 3;
    if (!f) begin t = hi; hi = lo; lo = t; end
    eh = 3'b001 << hi;
    el = 3'b001 << lo;
    return {eh, el};
  endfunction

  task automatic check(string req, logic [5:0] exp);
    n_chk++;
    if ({hs, ls} !== exp) begin
      n_fail++;
      $display("FAIL %s hall=%b fwd=%b en=%b brk_n=%b got hs=%b ls=%b exp hs=%b ls=%b",
               req, hall, fwd, en, brake_n, hs, ls, exp[5:3], exp[2:0]);
    end
  endtask

  task automatic apply(string req, logic [2:0] c, logic f, logic e, logic b);
    logic [5:0] old_v;
    @(negedge clk);
    old_v = {hs, ls};
    hall = c; fwd = f; en = e; brake_n = b;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", old_v);
    @(posedge clk);
    @(negedge clk);
    check(req, expect_of(c, f, e, b));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 6'b000000);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", 6'b000000);

    // R2 common positions, forward: explicit leg patterns
    apply("R2", 3'b001, 1, 1, 1); check("R2", {3'b001, 3'b100});
    apply("R2", 3'b011, 1, 1, 1); check("R2", {3'b010, 3'b100});
    apply("R2", 3'b110, 1, 1, 1); check("R2", {3'b100, 3'b001});
    apply("R2", 3'b100, 1, 1, 1); check("R2", {3'b100, 3'b010});
    // R3 120-only codes
    apply("R3", 3'b010, 1, 1, 1); check("R3", {3'b010, 3'b001});
    apply("R3", 3'b101, 1, 1, 1); check("R3", {3'b001, 3'b010});
    // R4 60-only codes match their twins
    apply("R4", 3'b111, 1, 1, 1); check("R4", {3'b010, 3'b001});
    apply("R4", 3'b000, 1, 1, 1); check("R4", {3'b001, 3'b010});
    // R5 reverse swaps
    apply("R5", 3'b001, 0, 1, 1); check("R5", {3'b100, 3'b001});
    apply("R5", 3'b000, 0, 1, 1); check("R5", {3'b010, 3'b001});

    // Exhaustive sweep over all codes, directions, enable and brake
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 2; b++)
        for (int f = 0; f < 2; f++)
          for (int c = 0; c < 8; c++) begin
            string r;
            r = (e == 0) ? "R7" : (b == 0) ? "R8" : (f == 0) ? "R5" : "R2";
            apply(r, 3'(c), 1'(f), 1'(e), 1'(b));
            if (e == 1 && b == 1) begin
              n_chk++;
              if ($countones(hs) != 1 || $countones(ls) != 1 || (hs & ls) != 0) begin
                n_fail++;
                $display("FAIL R6 hs=%b ls=%b exp one high one low disjoint", hs, ls);
              end
            end
          end

    // R7 enable overrides brake
    apply("R7", 3'b011, 1, 0, 0);
    check("R7", 6'b000000);
    // R8 brake with stable walk of codes
    apply("R8", 3'b110, 0, 1, 0);
    check("R8", {3'b111, 3'b000});

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule